// File: doc/BRIEF.md
# Mailbox Receive Window Frame

This block is the receiving half of an inter-processor mailbox. A sender elsewhere on the chip owns a shared bank of 32-bit status words, one word per channel window. This frame gives software on the receiving side a register view of those words. Software can read the raw bits and hide individual bits behind a per-bit mask. It can read the unmasked remainder and acknowledge bits by writing ones. Each acknowledgement leaves the block as a one-cycle clear strobe aimed at the shared storage.

Every window whose unmasked status is nonzero raises its own bit in a combined summary, 32 windows to a word. The handler can locate the lowest active window from those words without polling each window. One level-sensitive receive interrupt is raised when the summary holds any bit and the combined enable is on.

Top module: `mbrx_frame`

## Requirements
- R1: After reset every mask bit of every window reads 1. The receive interrupt is 0, the clear strobes are 0, the combined enable is 0 and the read data is 0.
- R2: A read at window offset +0x00 (window n at byte address n*0x20) returns that window's raw status input. A read at +0x04 returns status AND NOT mask.
- R3: A write to +0x14 ORs the written bits into that window's mask. The mask reads back at +0x10.
- R4: A write to +0x18 clears the written bits from that window's mask. Other windows are not affected.
- R5: A write to +0x08 drives the written bits onto that window's 32-bit slice of the clear strobe output for exactly the one cycle after the write. All other slices stay 0.
- R6: The write-only offsets +0x08, +0x14, +0x18 and the frame interrupt clear at 0xF94 read as zero.
- R7: Combined word k at 0xFA0+4k has bit j set exactly when window 32k+j has nonzero unmasked status. Bits for windows that do not exist read 0.
- R8: The receive interrupt output equals, one cycle later, the combined enable AND the OR of all combined bits.
- R9: The configuration word at 0xF80 returns the window count in bits 6:0 and zero elsewhere.
- R10: Bit 2 of the frame enable at 0xF98 is the combined enable and reads back. Its other bits read 0. Bit 2 of 0xF90 reports any pending combined bit, regardless of the enable.
- R11: Reads of unmapped addresses return 0. Writes to read-only or unmapped addresses change neither the masks nor the clear strobes.
- R12: Read data appears in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 12 | Byte address within the frame |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| win_status | input | NWIN*32 | Raw status of every window from shared storage |
| win_clear | output | NWIN*32 | One-cycle clear strobes back to shared storage |
| rx_irq | output | 1 | Receive interrupt, level |

## Verification
The bench models the shared status storage itself: it sets bits and applies the clear strobes, so acknowledgements are closed in a loop. Directed cases cover a bit that is pending while masked, the same bit once unmasked, and the same bit after acknowledgement. These separate the mask from the enable from the clear path. Random mixes of pending bits, mask set and clear writes and acknowledgements across all windows are then checked against a reference mask and enable model. The checks cover every readable offset and the interrupt level, which exposes cross-window leakage and inverted mask senses.

// File: rtl/mbrx_pkg.sv
package mbrx_pkg;

    localparam int WORD_W    = 32;
    localparam int CMB_WORDS = 4;
    localparam int CMB_BITS  = CMB_WORDS * WORD_W;
    localparam int EN_BIT    = 2;

    // window-relative offsets
    localparam logic [4:0] OFF_RAW  = 5'h00;
    localparam logic [4:0] OFF_MSKD = 5'h04;
    localparam logic [4:0] OFF_ACK  = 5'h08;
    localparam logic [4:0] OFF_MASK = 5'h10;
    localparam logic [4:0] OFF_MSET = 5'h14;
    localparam logic [4:0] OFF_MCLR = 5'h18;

    // frame-level addresses
    localparam logic [11:0] ADR_CFG  = 12'hF80;
    localparam logic [11:0] ADR_FST  = 12'hF90;
    localparam logic [11:0] ADR_FCLR = 12'hF94;
    localparam logic [11:0] ADR_FEN  = 12'hF98;

    typedef enum logic [3:0] {
        TGT_NONE,
        TGT_RAW,
        TGT_MSKD,
        TGT_ACK,
        TGT_MASK,
        TGT_MSET,
        TGT_MCLR,
        TGT_CFG,
        TGT_FST,
        TGT_FCLR,
        TGT_FEN,
        TGT_CMB
    } tgt_e;

endpackage

// File: rtl/mbrx_decode.sv
module mbrx_decode
    import mbrx_pkg::*;
#(
    parameter int NWIN = 4
) (
    input  logic [11:0] addr,
    output tgt_e        tgt,
    output logic [6:0]  win_idx,
    output logic [1:0]  cmb_idx
);
    localparam int WIN_SPAN = NWIN * 32;

    always_comb begin
        tgt     = TGT_NONE;
        win_idx = addr[11:5];
        cmb_idx = addr[3:2];
        if (int'(addr) < WIN_SPAN) begin
            case (addr[4:0])
                OFF_RAW:  tgt = TGT_RAW;
                OFF_MSKD: tgt = TGT_MSKD;
                OFF_ACK:  tgt = TGT_ACK;
                OFF_MASK: tgt = TGT_MASK;
                OFF_MSET: tgt = TGT_MSET;
                OFF_MCLR: tgt = TGT_MCLR;
                default:  tgt = TGT_NONE;
            endcase
        end else begin
            case (addr)
                ADR_CFG:  tgt = TGT_CFG;
                ADR_FST:  tgt = TGT_FST;
                ADR_FCLR: tgt = TGT_FCLR;
                ADR_FEN:  tgt = TGT_FEN;
                default: begin
                    if (addr[11:4] == 8'hFA && addr[1:0] == 2'b00)
                        tgt = TGT_CMB;
                end
            endcase
        end
    end

endmodule

// File: rtl/mbrx_mask_bank.sv
module mbrx_mask_bank
    import mbrx_pkg::*;
#(
    parameter int NWIN = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  tgt_e                   tgt,
    input  logic [6:0]             win_idx,
    input  logic [WORD_W-1:0]      wdata,
    output logic [NWIN*WORD_W-1:0] mask_flat
);

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        logic [WORD_W-1:0] mask_d, mask_q;
        logic              hit;

        assign hit = wr && (win_idx == 7'(g));

        always_comb begin
            mask_d = mask_q;
            if (hit && tgt == TGT_MSET)
                mask_d = mask_q | wdata;
            else if (hit && tgt == TGT_MCLR)
                mask_d = mask_q & ~wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) mask_q <= '1;
            else        mask_q <= mask_d;
        end

        assign mask_flat[g*WORD_W +: WORD_W] = mask_q;
    end

endmodule

// File: rtl/mbrx_summary.sv
module mbrx_summary
    import mbrx_pkg::*;
#(
    parameter int NWIN = 4
) (
    input  logic [NWIN*WORD_W-1:0] status,
    input  logic [NWIN*WORD_W-1:0] mask_flat,
    output logic [NWIN*WORD_W-1:0] masked,
    output logic [CMB_BITS-1:0]    cmb_flat,
    output logic                   any_hit
);
    localparam int PAD = CMB_BITS - NWIN;

    logic [NWIN-1:0] hit;

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        assign masked[g*WORD_W +: WORD_W] =
            status[g*WORD_W +: WORD_W] & ~mask_flat[g*WORD_W +: WORD_W];
        assign hit[g] = |masked[g*WORD_W +: WORD_W];
    end

    assign cmb_flat = {{PAD{1'b0}}, hit};
    assign any_hit  = |hit;

endmodule

// File: rtl/mbrx_frame.sv
module mbrx_frame
    import mbrx_pkg::*;
#(
    parameter int NWIN = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [11:0]            bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NWIN*32-1:0]     win_status,
    output logic [NWIN*32-1:0]     win_clear,
    output logic                   rx_irq
);
    localparam int FLAT_W = NWIN * WORD_W;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
        logic [FLAT_W-1:0] clr;
        logic              en;
        logic              irq;
    } frame_st_t;

    frame_st_t st_d, st_q;

    tgt_e              tgt;
    logic [6:0]        win_idx;
    logic [1:0]        cmb_idx;
    logic [FLAT_W-1:0] mask_flat;
    logic [FLAT_W-1:0] masked;
    logic [CMB_BITS-1:0] cmb_flat;
    logic              any_hit;
    logic              irq_en_q;
    logic [WORD_W-1:0] rd_val;

    mbrx_decode #(.NWIN(NWIN)) u_dec (
        .addr    (bus_addr),
        .tgt     (tgt),
        .win_idx (win_idx),
        .cmb_idx (cmb_idx)
    );

    mbrx_mask_bank #(.NWIN(NWIN)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .tgt       (tgt),
        .win_idx   (win_idx),
        .wdata     (bus_wdata),
        .mask_flat (mask_flat)
    );

    mbrx_summary #(.NWIN(NWIN)) u_sum (
        .status    (win_status),
        .mask_flat (mask_flat),
        .masked    (masked),
        .cmb_flat  (cmb_flat),
        .any_hit   (any_hit)
    );

    // read selection
    always_comb begin
        rd_val = '0;
        case (tgt)
            TGT_RAW, TGT_MSKD, TGT_MASK: begin
                for (int w = 0; w < NWIN; w++) begin
                    if (win_idx == 7'(w)) begin
                        if (tgt == TGT_RAW)
                            rd_val = win_status[w*WORD_W +: WORD_W];
                        else if (tgt == TGT_MSKD)
                            rd_val = masked[w*WORD_W +: WORD_W];
                        else
                            rd_val = mask_flat[w*WORD_W +: WORD_W];
                    end
                end
            end
            TGT_CFG: rd_val = {25'd0, 7'(NWIN)};
            TGT_FST: rd_val[EN_BIT] = any_hit;
            TGT_FEN: rd_val[EN_BIT] = st_q.en;
            TGT_CMB: rd_val = cmb_flat[cmb_idx*WORD_W +: WORD_W];
            default: rd_val = '0;
        endcase
    end

    // next state
    always_comb begin
        st_d     = st_q;
        st_d.clr = '0;
        if (bus_wr && tgt == TGT_ACK) begin
            for (int w = 0; w < NWIN; w++) begin
                if (win_idx == 7'(w))
                    st_d.clr[w*WORD_W +: WORD_W] = bus_wdata;
            end
        end
        if (bus_wr && tgt == TGT_FEN)
            st_d.en = bus_wdata[EN_BIT];
        st_d.irq = st_q.en & any_hit;
        if (bus_rd)
            st_d.rdata = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign win_clear = st_q.clr;
    assign rx_irq    = st_q.irq;
    assign irq_en_q  = st_q.en;

endmodule

// File: rtl/mbrx_frame_chk.sv
module mbrx_frame_chk #(
    parameter int NWIN = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [31:0]        bus_rdata,
    input logic [NWIN*32-1:0] win_status,
    input logic [NWIN*32-1:0] win_clear,
    input logic               rx_irq,
    input logic               irq_en_q,
    input logic [NWIN*32-1:0] mask_flat
);

    // R5
    clear_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|win_clear) |-> $past(bus_wr));

    // R3
    mask_rise_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(mask_flat & ~$past(mask_flat))) |-> $past(bus_wr));

    // R8
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> $past(irq_en_q));

    // R8
    irq_follows_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(irq_en_q && (|(win_status & ~mask_flat))) |-> rx_irq);

    // R12
    rdata_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> $stable(bus_rdata));

endmodule

bind mbrx_frame mbrx_frame_chk #(.NWIN(NWIN)) u_chk (.*);

// File: tb/mbrx_frame_test.sv
module mbrx_frame_test;
    localparam int NW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NW*32-1:0]  win_status;
    logic [NW*32-1:0]  win_clear;
    logic              rx_irq;

    logic [NW*32-1:0]  stat = '0;
    logic [NW*32-1:0]  set_pend = '0;
    logic [31:0]       mask_m [NW];
    logic              en_m = 1'b0;
    int                checks = 0;
    int                fails = 0;
    bit                done = 1'b0;

    always #5 clk = ~clk;

    // shared status storage model
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~win_clear) | set_pend;
    end
    assign win_status = stat;

    mbrx_frame #(.NWIN(NW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .win_status(win_status), .win_clear(win_clear), .rx_irq(rx_irq)
    );

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [11:0] a);
        logic [31:0] r = '0;
        logic [NW-1:0] hit;
        for (int w = 0; w < NW; w++) hit[w] = |(stat[w*32 +: 32] & ~mask_m[w]);
        if (int'(a) < NW*32) begin
            case (a[4:0])
                5'h00: r = stat[a[11:5]*32 +: 32];
                5'h04: r = stat[a[11:5]*32 +: 32] & ~mask_m[a[11:5]];
                5'h10: r = mask_m[a[11:5]];
                default: r = '0;
            endcase
        end else if (a == 12'hF80) r = NW;
        else if (a == 12'hF90) r = {29'd0, |hit, 2'd0};
        else if (a == 12'hF98) r = {29'd0, en_m, 2'd0};
        else if (a == 12'hFA0) r = {{(32-NW){1'b0}}, hit};
        return r;
    endfunction

    function automatic logic exp_irq();
        logic any = 1'b0;
        for (int w = 0; w < NW; w++) any |= |(stat[w*32 +: 32] & ~mask_m[w]);
        return en_m & any;
    endfunction

    task automatic do_write(logic [11:0] a, logic [31:0] d, output logic [NW*32-1:0] clr_seen);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        clr_seen = win_clear;
        if (int'(a) < NW*32) begin
            if (a[4:0] == 5'h14) mask_m[a[11:5]] = mask_m[a[11:5]] | d;
            if (a[4:0] == 5'h18) mask_m[a[11:5]] = mask_m[a[11:5]] & ~d;
        end else if (a == 12'hF98) en_m = d[2];
    endtask

    task automatic do_read(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pend(logic [NW*32-1:0] v);
        @(negedge clk);
        set_pend = v;
        @(negedge clk);
        set_pend = '0;
    endtask

    task automatic settle_irq(string req);
        @(negedge clk);
        @(negedge clk);
        chk(req, 128'(rx_irq), 128'(exp_irq()));
    endtask

    task automatic rd_chk(string req, logic [11:0] a);
        logic [31:0] d;
        logic [31:0] e;
        e = exp_read(a);
        do_read(a, d);
        chk(req, 128'(d), 128'(e));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [NW*32-1:0] cs;
        logic [NW*32-1:0] ecs;
        logic [31:0] d;
        void'($urandom(32'h5eed_1234));
        for (int w = 0; w < NW; w++) mask_m[w] = '1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", 128'(rx_irq), 128'(0));
        chk("R1 clear", 128'(win_clear), 128'(0));
        chk("R1 rdata", 128'(bus_rdata), 128'(0));
        for (int w = 0; w < NW; w++) rd_chk("R1 mask", 12'(w*32 + 16));
        rd_chk("R1 enable", 12'hF98);

        // R9 configuration
        rd_chk("R9 cfg", 12'hF80);

        // masked pending bit: no interrupt
        pend(128'(1) << (2*32 + 5));
        rd_chk("R2 raw", 12'h040);
        rd_chk("R2 masked", 12'h044);
        rd_chk("R7 cmb masked", 12'hFA0);
        do_write(12'hF98, 32'hFFFF_FFFF, cs);
        rd_chk("R10 enable readback", 12'hF98);
        settle_irq("R8 masked bit");

        // unmask it
        do_write(12'h058, 32'h0000_0020, cs);
        rd_chk("R4 mask clear", 12'h050);
        rd_chk("R4 other window", 12'h030);
        rd_chk("R7 cmb", 12'hFA0);
        rd_chk("R10 pending", 12'hF90);
        settle_irq("R8 unmasked bit");
        chk("R8 irq high", 128'(rx_irq), 128'(1));

        // R12 holds without read
        d = bus_rdata;
        repeat (3) @(negedge clk);
        chk("R12 hold", 128'(bus_rdata), 128'(d));

        // R6 write-only offsets
        rd_chk("R6 ack", 12'h048);
        rd_chk("R6 mset", 12'h054);
        rd_chk("R6 mclr", 12'h058);
        rd_chk("R6 fclr", 12'hF94);

        // R11 writes to read-only and unmapped locations
        do_write(12'h040, 32'hFFFF_FFFF, cs);
        chk("R11 raw write no strobe", 128'(cs), 128'(0));
        do_write(12'h700, 32'hFFFF_FFFF, cs);
        chk("R11 unmapped write no strobe", 128'(cs), 128'(0));
        rd_chk("R11 mask kept", 12'h050);
        rd_chk("R11 unmapped read", 12'h700);
        rd_chk("R7 word1 zero", 12'hFA4);

        // R5 acknowledge
        do_write(12'h048, 32'h0000_0020, cs);
        chk("R5 strobe", 128'(cs), 128'(1) << (2*32 + 5));
        @(negedge clk);
        chk("R5 one cycle", 128'(win_clear), 128'(0));
        rd_chk("R5 raw cleared", 12'h040);
        settle_irq("R8 after ack");
        chk("R8 irq low", 128'(rx_irq), 128'(0));

        // R3 mask set
        do_write(12'h014, 32'h00F0_0000, cs);
        rd_chk("R3 mask set", 12'h010);

        // random mix
        for (int i = 0; i < 300; i++) begin
            int op;
            int w;
            logic [31:0] v;
            op = int'($urandom_range(0, 5));
            w  = int'($urandom_range(0, NW-1));
            v  = $urandom() & $urandom();
            case (op)
                0: pend(128'(v) << (w*32));
                1: do_write(12'(w*32 + 20), v, cs);
                2: do_write(12'(w*32 + 24), v, cs);
                3: begin
                    ecs = 128'(v) << (w*32);
                    do_write(12'(w*32 + 8), v, cs);
                    chk("R5 random strobe", 128'(cs), 128'(ecs));
                end
                4: do_write(12'hF98, v, cs);
                default: ;
            endcase
            @(negedge clk);
            rd_chk("R2 random raw", 12'(w*32));
            rd_chk("R2 random masked", 12'(w*32 + 4));
            rd_chk("R3 random mask", 12'(w*32 + 16));
            rd_chk("R7 random cmb", 12'hFA0);
            rd_chk("R10 random pending", 12'hF90);
            settle_irq("R8 random irq");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule